// File: doc/BRIEF.md
# Flash Program/Erase Status Word Generator

This block builds the byte that a parallel NOR-style flash device returns on a read while its internal program/erase controller is working. It does not hold the memory array. Array data comes in on a data port, and the block decides on each read whether to pass that data through or to return a status word. When a status word is returned, each bit follows its own rule. One bit is a polling bit that carries the complement of the data being written. Two toggle bits flip once per completed read, and they are qualified by different conditions. There is also a failure bit and an erase-window bit. The rest of the byte is fixed at zero.

Two inputs, `prog_busy` and `erase_busy`, say which operation the controller is running. The block counts write strobes and trusts the status only once the command sequence is long enough. After an operation ends, the block keeps returning a completion word until the next command sequence starts. A separate input opens a fixed-length window. During that window the polling bit reads low, which models an erase that found all of its selected blocks protected.

Top module: `flash_status_gen`

## Requirements
- R1: While a program is in progress and status is valid, bit 7 of the returned word is the inverse of `prog_bit`. While an erase is in progress, bit 7 is 0.
- R2: Once a valid operation ends, reads return a completion word until `seq_clr` is pulsed. In that word, bit 7 is the last programmed bit (or 1 after an erase), bit 3 is 1 after an erase and 0 after a program, and bits 6 and 2 no longer change.
- R3: Bit 6 inverts after every completed read (a read whose `rd_en` is then deasserted) taken while a program, an erase or the protected window is active. It holds its level in the completion word and during an erase suspend.
- R4: Bit 5 equals `fail` in program, erase and completion words. It is 0 in a suspended-erase word.
- R5: During an erase, bit 3 is 0 while `win_open` is 1 and is 1 once `win_open` is 0. It is 0 during a program and 1 in a suspended-erase word.
- R6: Bit 2 inverts after a completed read only when the read is made during an erase (running or suspended) and `erase_mask[rd_blk]` is 1. It holds its level during a program and on reads of unselected blocks.
- R7: A program returns status only after at least PROG_STB (4) write strobes, and an erase only after at least ERASE_STB (6) strobes, counted since the last `seq_clr`. Before that, reads return `arr_data`.
- R8: After a `prot_start` pulse, reads return a word with bit 7 = 0, bit 3 = 1 and the toggle bits in positions 6 and 2, for CLK_MHZ*PROT_US clock cycles. After that, reads return array data again. This window takes priority over every other mode.
- R9: Bits 4, 1 and 0 are 0 in every status word.
- R10: With no valid operation, no completion word pending and no protected window, reads return `arr_data`. During an erase suspend, a read of a block not selected in `erase_mask` also returns `arr_data`.
- R11: After reset, `rd_data` is 0 and both toggle bits start at 0.
- R12: `rd_data` is registered. It takes the new word at the clock edge that samples `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle pulse for each bus write strobe of a command sequence |
| seq_clr | input | 1 | Starts a new command sequence: clears the strobe count and the completion word |
| prog_busy | input | 1 | Controller is programming |
| erase_busy | input | 1 | Controller is erasing |
| prog_bit | input | 1 | Bit 7 of the data being programmed |
| erase_mask | input | NBLK | One bit per block selected for erase |
| susp_ack | input | 1 | Erase suspend acknowledged |
| fail | input | 1 | Program or erase failure |
| win_open | input | 1 | Erase timeout window still open (more blocks may be queued) |
| prot_start | input | 1 | Pulse: every selected block is protected; opens the protected window |
| rd_en | input | 1 | Read strobe, high for the read cycle |
| rd_blk | input | BLK_BITS | Block field of the read address |
| arr_data | input | 8 | Array data for pass-through reads |
| rd_data | output | 8 | Registered read data or status word |

## Verification
The bench steers into the places where status rules interact. These include a command sequence one strobe short of its threshold, which a faulty counter would answer with status instead of array data. They also include the first read after the busy input drops, where a design that lost the completion state for a cycle would leak array data. The bench checks suspended erases on selected and unselected blocks: a design that qualified the second toggle bit badly would flip on the wrong block or freeze it, and one that did not fall back to array data would return status for an unselected block. It also checks reads inside and past the protected window, where an off-by-many timer would hold bit 7 low too long or too briefly.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    M_ARRAY = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_SUSP  = 3'd3,
    M_DONE  = 3'd4,
    M_PROT  = 3'd5
  } fsg_mode_e;

  localparam int POLL_BIT = 7;
  localparam int TOG_A_BIT = 6;
  localparam int ERR_BIT = 5;
  localparam int TMR_BIT = 3;
  localparam int TOG_B_BIT = 2;

  function automatic logic mode_flips_a(fsg_mode_e m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_PROT);
  endfunction

  function automatic logic mode_erasing(fsg_mode_e m);
    return (m == M_ERASE) || (m == M_SUSP);
  endfunction

endpackage

// File: rtl/fsg_rst_sync.sv
module fsg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fsg_prot_timer.sv
module fsg_prot_timer #(
  parameter int CLK_MHZ = 200,
  parameter int PROT_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prot_start,
  output logic prot_on
);
  localparam int LIM = CLK_MHZ * PROT_US;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIM);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = prot_start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (prot_start)        cnt_d = LIM_V;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign prot_on = (cnt_q != '0);
endmodule

// File: rtl/fsg_seq_track.sv
module fsg_seq_track
  import fsg_pkg::*;
#(
  parameter int PROG_STB  = 4,
  parameter int ERASE_STB = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_stb,
  input  logic      seq_clr,
  input  logic      prog_busy,
  input  logic      erase_busy,
  input  logic      prog_bit,
  input  logic      susp_ack,
  input  logic      prot_on,
  output fsg_mode_e mode,
  output logic      done_erase,
  output logic      last_bit
);
  localparam int CNT_MAX = (ERASE_STB > PROG_STB) ? ERASE_STB : PROG_STB;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] MAX_V = CW'(CNT_MAX);
  localparam logic [CW-1:0] PROG_V = CW'(PROG_STB);
  localparam logic [CW-1:0] ERASE_V = CW'(ERASE_STB);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          done_q, done_d;
  logic          kind_q, kind_d;
  logic          last_q, last_d;
  logic          valid_e, valid_p, active, done_now;

  always_comb begin
    valid_e  = erase_busy && (cnt_q >= ERASE_V);
    valid_p  = prog_busy && !valid_e && (cnt_q >= PROG_V);
    active   = valid_e || valid_p;
    done_now = (done_q || act_q) && !active && !seq_clr;

    cnt_d = cnt_q;
    if (seq_clr)                     cnt_d = '0;
    else if (wr_stb && cnt_q != MAX_V) cnt_d = cnt_q + 1'b1;

    act_d  = active;
    done_d = done_now;
    kind_d = active ? valid_e : kind_q;
    last_d = valid_p ? prog_bit : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      kind_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      done_q <= done_d;
      kind_q <= kind_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    if (prot_on)       mode = M_PROT;
    else if (valid_e)  mode = susp_ack ? M_SUSP : M_ERASE;
    else if (valid_p)  mode = M_PROG;
    else if (done_now) mode = M_DONE;
    else               mode = M_ARRAY;
  end

  assign done_erase = kind_q;
  assign last_bit   = last_q;
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle
  import fsg_pkg::*;
#(
  parameter int BLK_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [BLK_BITS-1:0]      rd_blk,
  input  logic [(1<<BLK_BITS)-1:0] erase_mask,
  input  fsg_mode_e                mode,
  output logic                     hit,
  output logic                     tog_a,
  output logic                     tog_b,
  output logic                     rd_fall
);
  logic rd_q;
  logic flip_a_q, flip_a_d;
  logic flip_b_q, flip_b_d;
  logic tog_a_q, tog_a_d;
  logic tog_b_q, tog_b_d;

  always_comb begin
    hit      = erase_mask[rd_blk];
    rd_fall  = rd_q && !rd_en;
    flip_a_d = mode_flips_a(mode);
    flip_b_d = mode_erasing(mode) && hit;
    tog_a_d  = tog_a_q ^ flip_a_q;
    tog_b_d  = tog_b_q ^ flip_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      flip_a_q <= 1'b0;
      flip_b_q <= 1'b0;
      tog_a_q  <= 1'b0;
      tog_b_q  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (rd_en) begin
        flip_a_q <= flip_a_d;
        flip_b_q <= flip_b_d;
      end
      if (rd_fall) begin
        tog_a_q <= tog_a_d;
        tog_b_q <= tog_b_d;
      end
    end
  end

  assign tog_a = tog_a_q;
  assign tog_b = tog_b_q;
endmodule

// File: rtl/fsg_word_mux.sv
module fsg_word_mux
  import fsg_pkg::*;
(
  input  fsg_mode_e  mode,
  input  logic       prog_bit,
  input  logic       last_bit,
  input  logic       done_erase,
  input  logic       fail,
  input  logic       win_open,
  input  logic       tog_a,
  input  logic       tog_b,
  input  logic       hit,
  input  logic [7:0] arr_data,
  output logic [7:0] word,
  output logic       st_sel
);
  logic [7:0] st;

  always_comb begin
    st     = 8'h00;
    st_sel = 1'b1;
    st[TOG_A_BIT] = tog_a;
    st[TOG_B_BIT] = tog_b;
    unique case (mode)
      M_PROG: begin
        st[POLL_BIT] = !prog_bit;
        st[ERR_BIT]  = fail;
      end
      M_ERASE: begin
        st[ERR_BIT] = fail;
        st[TMR_BIT] = !win_open;
      end
      M_SUSP: begin
        st[POLL_BIT] = 1'b1;
        st[TMR_BIT]  = 1'b1;
        st_sel       = hit;
      end
      M_DONE: begin
        st[POLL_BIT] = done_erase ? 1'b1 : last_bit;
        st[ERR_BIT]  = fail;
        st[TMR_BIT]  = done_erase;
      end
      M_PROT: begin
        st[TMR_BIT] = 1'b1;
      end
      default: st_sel = 1'b0;
    endcase
    word = st_sel ? st : arr_data;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int BLK_BITS  = 2,
  parameter int PROG_STB  = 4,
  parameter int ERASE_STB = 6,
  parameter int CLK_MHZ   = 200,
  parameter int PROT_US   = 100,
  localparam int NBLK     = 1 << BLK_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic                seq_clr,
  input  logic                prog_busy,
  input  logic                erase_busy,
  input  logic                prog_bit,
  input  logic [NBLK-1:0]     erase_mask,
  input  logic                susp_ack,
  input  logic                fail,
  input  logic                win_open,
  input  logic                prot_start,
  input  logic                rd_en,
  input  logic [BLK_BITS-1:0] rd_blk,
  input  logic [7:0]          arr_data,
  output logic [7:0]          rd_data
);
  logic       rst_i_n;
  logic       prot_on;
  fsg_mode_e  mode;
  logic       done_erase, last_bit;
  logic       hit, tog_a, tog_b, rd_fall;
  logic [7:0] word;
  logic       st_sel;
  logic [7:0] rd_data_q;

  fsg_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  fsg_prot_timer #(.CLK_MHZ(CLK_MHZ), .PROT_US(PROT_US)) u_prot (
    .clk(clk), .rst_n(rst_i_n), .prot_start(prot_start), .prot_on(prot_on)
  );

  fsg_seq_track #(.PROG_STB(PROG_STB), .ERASE_STB(ERASE_STB)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .wr_stb(wr_stb), .seq_clr(seq_clr),
    .prog_busy(prog_busy), .erase_busy(erase_busy), .prog_bit(prog_bit),
    .susp_ack(susp_ack), .prot_on(prot_on), .mode(mode),
    .done_erase(done_erase), .last_bit(last_bit)
  );

  fsg_toggle #(.BLK_BITS(BLK_BITS)) u_tog (
    .clk(clk), .rst_n(rst_i_n), .rd_en(rd_en), .rd_blk(rd_blk),
    .erase_mask(erase_mask), .mode(mode), .hit(hit),
    .tog_a(tog_a), .tog_b(tog_b), .rd_fall(rd_fall)
  );

  fsg_word_mux u_mux (
    .mode(mode), .prog_bit(prog_bit), .last_bit(last_bit),
    .done_erase(done_erase), .fail(fail), .win_open(win_open),
    .tog_a(tog_a), .tog_b(tog_b), .hit(hit), .arr_data(arr_data),
    .word(word), .st_sel(st_sel)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   rd_data_q <= 8'h00;
    else if (rd_en) rd_data_q <= word;
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
  import fsg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       prog_bit,
  input fsg_mode_e  mode,
  input logic       tog_a,
  input logic       rd_fall,
  input logic       st_sel
);
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_poll_prog_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == M_PROG) |=> (rd_data[7] == !$past(prog_bit)));

  assert_poll_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == M_PROT) |=> (rd_data[7] == 1'b0));

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st_sel) |=> (rd_data[4] == 1'b0 && rd_data[1] == 1'b0 && rd_data[0] == 1'b0));

  assert_tog_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog_a) |-> $past(rd_fall));
endmodule

bind flash_status_gen fsg_checker u_fsg_chk (
  .clk(clk), .rst_n(rst_i_n), .rd_en(rd_en), .rd_data(rd_data),
  .prog_bit(prog_bit), .mode(mode), .tog_a(tog_a), .rd_fall(rd_fall),
  .st_sel(st_sel)
);

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
  localparam int BB = 2;
  localparam int NB = 4;
  localparam int PRT = 100;
  localparam int MA = 0, MP = 1, ME = 2, MS = 3, MD = 4, MX = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_stb, seq_clr, prog_busy, erase_busy, prog_bit;
  logic [NB-1:0] erase_mask;
  logic susp_ack, fail, win_open, prot_start, rd_en;
  logic [BB-1:0] rd_blk;
  logic [7:0] arr_data, rd_data;

  int n_chk = 0, n_fail = 0;
  bit m_ta, m_tb, b_done, b_derase, b_last, b_prot;
  int b_cnt;

  flash_status_gen #(.BLK_BITS(BB), .CLK_MHZ(1), .PROT_US(PRT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .seq_clr(seq_clr),
    .prog_busy(prog_busy), .erase_busy(erase_busy), .prog_bit(prog_bit),
    .erase_mask(erase_mask), .susp_ack(susp_ack), .fail(fail),
    .win_open(win_open), .prot_start(prot_start), .rd_en(rd_en),
    .rd_blk(rd_blk), .arr_data(arr_data), .rd_data(rd_data)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  function automatic bit v_erase();
    return erase_busy && b_cnt >= 6;
  endfunction
  function automatic bit v_prog();
    return prog_busy && !v_erase() && b_cnt >= 4;
  endfunction

  function automatic int bmode();
    if (b_prot) return MX;
    if (v_erase()) return susp_ack ? MS : ME;
    if (v_prog()) return MP;
    if (b_done) return MD;
    return MA;
  endfunction

  function automatic logic [7:0] expw(int md, logic [BB-1:0] blk);
    logic [7:0] w;
    w = 8'h00; w[6] = m_ta; w[2] = m_tb;
    case (md)
      MP: begin w[7] = !prog_bit; w[5] = fail; end
      ME: begin w[5] = fail; w[3] = !win_open; end
      MS: begin w[7] = 1'b1; w[3] = 1'b1; if (!erase_mask[blk]) w = arr_data; end
      MD: begin w[7] = b_derase ? 1'b1 : b_last; w[5] = fail; w[3] = b_derase; end
      MX: w[3] = 1'b1;
      default: w = arr_data;
    endcase
    return w;
  endfunction

  function automatic string mtag(int md);
    case (md)
      MP: return "R1";
      ME: return "R5";
      MS: return "R6";
      MD: return "R2";
      MX: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic do_read(logic [BB-1:0] blk);
    int md;
    logic [7:0] e;
    md = bmode();
    e = expw(md, blk);
    rd_en = 1'b1; rd_blk = blk;
    @(negedge clk);
    chk(mtag(md), rd_data, e);
    if (md != MA && !(md == MS && !erase_mask[blk]))
      chk("R9", rd_data & 8'h13, 8'h00);
    if (md == MP || md == ME || md == MD) chk("R4", {7'd0, rd_data[5]}, {7'd0, fail});
    rd_en = 1'b0;
    if (md == MP || md == ME || md == MX) m_ta = !m_ta;
    if ((md == ME || md == MS) && erase_mask[blk]) m_tb = !m_tb;
    if (v_prog()) b_last = prog_bit;
    @(negedge clk);
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0;
      if (b_cnt < 6) b_cnt++;
    end
  endtask

  task automatic clr();
    seq_clr = 1'b1; @(negedge clk); seq_clr = 1'b0;
    b_cnt = 0; b_done = 1'b0;
  endtask

  task automatic end_op();
    if (v_erase() || v_prog()) begin b_done = 1'b1; b_derase = v_erase(); end
    prog_busy = 1'b0; erase_busy = 1'b0; susp_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    rst_n = 0; wr_stb = 0; seq_clr = 0; prog_busy = 0; erase_busy = 0;
    prog_bit = 0; erase_mask = '0; susp_ack = 0; fail = 0; win_open = 1;
    prot_start = 0; rd_en = 0; rd_blk = '0; arr_data = 8'h5A;
    m_ta = 0; m_tb = 0; b_done = 0; b_derase = 0; b_last = 0; b_prot = 0; b_cnt = 0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk("R11 reset", rd_data, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R11 after release", rd_data, 8'h00);

    // idle read returns array data, then holds while rd_en low
    arr_data = 8'hC3; do_read(2'd1);
    hold = rd_data; arr_data = 8'h3C; repeat (3) @(negedge clk);
    chk("R12 hold", rd_data, hold);

    // program one strobe short: still array data
    clr(); prog_busy = 1; prog_bit = 1; strobes(3);
    arr_data = 8'h81; do_read(2'd0);
    chk("R7 short prog", rd_data, 8'h81);
    strobes(1);
    do_read(2'd0); chk("R3 first flip", {7'd0, rd_data[6]}, 8'd0);
    do_read(2'd0); chk("R3 second flip", {7'd0, rd_data[6]}, 8'd1);
    end_op(); do_read(2'd0);
    chk("R2 prog done poll", {7'd0, rd_data[7]}, 8'd1);
    do_read(2'd0); do_read(2'd0);
    chk("R3 done constant", {7'd0, rd_data[6]}, {7'd0, m_ta});

    // erase, suspended, hit and miss blocks
    clr(); erase_mask = 4'b0100; erase_busy = 1; win_open = 1; strobes(5);
    arr_data = 8'h77; do_read(2'd2);
    chk("R7 short erase", rd_data, 8'h77);
    strobes(1);
    do_read(2'd2); do_read(2'd3); do_read(2'd2);
    win_open = 0; do_read(2'd2);
    susp_ack = 1; arr_data = 8'hE1; do_read(2'd3);
    chk("R10 suspend miss", rd_data, 8'hE1);
    do_read(2'd2); do_read(2'd2);
    end_op(); do_read(2'd1);
    chk("R2 erase done", rd_data & 8'h88, 8'h88);

    // protected window
    clr(); arr_data = 8'h42;
    prot_start = 1; @(negedge clk); prot_start = 0; b_prot = 1;
    do_read(2'd0); do_read(2'd1);
    chk("R8 inside", {7'd0, rd_data[7]}, 8'd0);
    repeat (PRT + 20) @(negedge clk);
    b_prot = 0; do_read(2'd0);
    chk("R8 after", rd_data, 8'h42);

    // constrained random operations
    for (int op = 0; op < 80; op++) begin
      bit er;
      int thr;
      clr();
      er = $urandom_range(1, 0) == 1;
      erase_mask = NB'($urandom_range(15, 1));
      prog_bit = $urandom_range(1, 0) == 1; fail = 0; win_open = 1; susp_ack = 0;
      if (er) erase_busy = 1; else prog_busy = 1;
      thr = er ? 6 : 4;
      if ($urandom_range(3, 0) == 0) thr = thr - 1;
      strobes(thr);
      for (int k = 0; k < 2 + int'($urandom_range(5, 0)); k++) begin
        prog_bit = $urandom_range(1, 0) == 1;
        fail = $urandom_range(7, 0) == 0;
        win_open = $urandom_range(1, 0) == 1;
        if (er) susp_ack = $urandom_range(2, 0) == 0;
        arr_data = 8'($urandom);
        do_read(BB'($urandom_range(NB - 1, 0)));
      end
      end_op();
      for (int k = 0; k < 3; k++) begin
        arr_data = 8'($urandom);
        do_read(BB'($urandom_range(NB - 1, 0)));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule